// File: doc/BRIEF.md
# Parallel EPROM Byte-Read Sequencer

This block sits on the host side of an external byte-wide parallel EPROM with an 18-bit address and reads one byte per request. A host presents an address together with a valid flag. Once the block is free it takes the request, puts the address on the memory bus and pulls the select line low. It lowers the read strobe only as late as the timing allows, and takes the byte off the data bus at the first clock edge that meets every access limit. It then raises both strobes together and waits for the memory to stop driving the bus before it takes the next request.

All timing limits are given in nanoseconds together with the clock period. Each limit is turned into a whole number of clock cycles, rounded up, with a minimum of one cycle. The select line works as the decoded device select and the read strobe as the gate onto the data bus. The data bus is therefore only driven while both lines are low.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: In reset and in the first cycle after it, `mem_ce_n` and `mem_oe_n` are 1, `req_ready` is 1 and `rd_valid` is 0.
- R2: A request is taken at a rising edge where `req_valid` and `req_ready` are both 1. From that edge `req_ready` stays 0 until the bus turnaround has finished.
- R3: `mem_ce_n` goes low at the taking edge and `mem_addr` shows the taken address from that same edge. The address does not change while `mem_ce_n` stays low.
- R4: `mem_oe_n` goes low LEAD edges after `mem_ce_n`, where LEAD = max(ACC, CE) − OE clamped at zero. ACC, CE and OE are the address, select and strobe access times in cycles. `mem_oe_n` is never low while `mem_ce_n` is high.
- R5: The data bus is sampled at the edge TOTAL = max(ACC, CE) cycles after the taking edge. That byte appears on `rd_data` with `rd_valid` = 1 for exactly one cycle.
- R6: `mem_ce_n` and `mem_oe_n` rise together at the sampling edge. They are both high whenever `rd_valid` is 1.
- R7: `req_ready` returns to 1 DF cycles after the sampling edge, where DF is the bus release time in cycles. `mem_ce_n` never falls less than DF cycles after the strobes were raised.
- R8: Each cycle count equals the nanosecond limit divided by the clock period, rounded up, and is at least 1. With the defaults (20 ns clock; 120/120/50/40 ns) this gives ACC = 6, CE = 6, OE = 3 and DF = 2.
- R9: A `req_valid` or `req_addr` change while `req_ready` is 0 has no effect. The bus address, the strobes and the returned byte of the access in progress stay unchanged, and no extra access follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host read request |
| req_addr | input | ADDR_W | Byte address of the request |
| req_ready | output | 1 | Block can take a request |
| rd_data | output | DATA_W | Byte returned by the last read |
| rd_valid | output | 1 | One-cycle pulse marking `rd_data` |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_ce_n | output | 1 | Active-low device select |
| mem_oe_n | output | 1 | Active-low read strobe |
| mem_dq | input | DATA_W | Memory data bus |

## Verification
Two sets of events can fall on the same clock edge, and both are checked. At the sampling edge the byte is captured while both strobes are released. At the first ready cycle after the turnaround, the next request can be taken while the bus has only just come free. The bench exercises both by holding `req_valid` high through a series of back-to-back reads. It uses a memory model that returns the inverted byte whenever the select, strobe or address time has not yet elapsed before the edge, so a byte captured one edge early is wrong. It also checks at every falling edge of the select line that the release time since the strobes were raised has elapsed. A cycle-by-cycle reference of strobes, ready and returned data is compared on every clock, so a strobe that moves one cycle early or late is reported.

// File: rtl/eprom_rd_pkg.sv
`timescale 1ns/1ps
package eprom_rd_pkg;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_ACCESS  = 2'd1,
        PH_RELEASE = 2'd2
    } phase_t;

    // nanoseconds to whole clock cycles, rounded up, never below one
    function automatic int ns_to_cycles(input int ns, input int period_ns);
        int r;
        r = (ns + period_ns - 1) / period_ns;
        if (r < 1) r = 1;
        return r;
    endfunction

    function automatic int int_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/eprom_rd_seq.sv
`timescale 1ns/1ps
module eprom_rd_seq
    import eprom_rd_pkg::*;
#(
    parameter int ADDR_W  = 18,
    parameter int TOTAL_C = 6,
    parameter int LEAD_C  = 3,
    parameter int DF_C    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              sample
);
    localparam int CNT_W = $clog2(int_max(TOTAL_C, DF_C) + 1) + 1;
    localparam logic [CNT_W-1:0] LAST_ACC = CNT_W'(TOTAL_C - 1);
    localparam logic [CNT_W-1:0] LAST_REL = CNT_W'(DF_C - 1);
    localparam logic [CNT_W-1:0] OE_EDGE  = CNT_W'(int_max(LEAD_C, 1) - 1);
    localparam bit               OE_AT_START = (LEAD_C == 0);

    phase_t           phase;
    logic [CNT_W-1:0] cnt;

    assign req_ready = (phase == PH_IDLE);
    assign sample    = (phase == PH_ACCESS) && (cnt == LAST_ACC);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            cnt      <= '0;
            mem_addr <= '0;
            mem_ce_n <= 1'b1;
            mem_oe_n <= 1'b1;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (req_valid) begin
                        phase    <= PH_ACCESS;
                        cnt      <= '0;
                        mem_addr <= req_addr;
                        mem_ce_n <= 1'b0;
                        mem_oe_n <= !OE_AT_START;
                    end
                end
                PH_ACCESS: begin
                    cnt <= cnt + 1'b1;
                    if (!OE_AT_START && cnt == OE_EDGE)
                        mem_oe_n <= 1'b0;
                    if (cnt == LAST_ACC) begin
                        phase    <= PH_RELEASE;
                        cnt      <= '0;
                        mem_ce_n <= 1'b1;
                        mem_oe_n <= 1'b1;
                    end
                end
                PH_RELEASE: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST_REL)
                        phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    AST_OE_UNDER_CE: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> !mem_ce_n);                                   // R4
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));     // R3
    AST_READY_BUS_IDLE: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_ce_n && mem_oe_n));                      // R7
    AST_TAKE_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (!req_ready && !mem_ce_n));    // R2

endmodule

// File: rtl/eprom_rd_capture.sv
`timescale 1ns/1ps
module eprom_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample,
    input  logic [DATA_W-1:0] mem_dq,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= sample;
            if (sample)
                rd_data <= mem_dq;
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);                                    // R5

endmodule

// File: rtl/eprom_rd_ctrl.sv
`timescale 1ns/1ps
module eprom_rd_ctrl
    import eprom_rd_pkg::*;
#(
    parameter int ADDR_W        = 18,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 20,
    parameter int T_ACC_NS      = 120,
    parameter int T_CE_NS       = 120,
    parameter int T_OE_NS       = 50,
    parameter int T_DF_NS       = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    input  logic [DATA_W-1:0] mem_dq
);
    // R8: every limit rounded up to whole cycles
    localparam int ACC_C   = ns_to_cycles(T_ACC_NS, CLK_PERIOD_NS);
    localparam int CE_C    = ns_to_cycles(T_CE_NS,  CLK_PERIOD_NS);
    localparam int OE_C    = ns_to_cycles(T_OE_NS,  CLK_PERIOD_NS);
    localparam int DF_C    = ns_to_cycles(T_DF_NS,  CLK_PERIOD_NS);
    localparam int TOTAL_C = int_max(ACC_C, CE_C);
    localparam int LEAD_C  = int_max(TOTAL_C - OE_C, 0);

    logic sample;

    eprom_rd_seq #(
        .ADDR_W  (ADDR_W),
        .TOTAL_C (TOTAL_C),
        .LEAD_C  (LEAD_C),
        .DF_C    (DF_C)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_ready (req_ready),
        .mem_addr  (mem_addr),
        .mem_ce_n  (mem_ce_n),
        .mem_oe_n  (mem_oe_n),
        .sample    (sample)
    );

    eprom_rd_capture #(
        .DATA_W (DATA_W)
    ) u_cap (
        .clk      (clk),
        .rst      (rst),
        .sample   (sample),
        .mem_dq   (mem_dq),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    AST_SAMPLE_RELEASES: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (mem_ce_n && mem_oe_n));                       // R6
    AST_RETURN_AFTER_ACCESS: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> !req_ready);                                   // R7

endmodule

// File: tb/sim_eprom_rd_ctrl.sv
`timescale 1ns/1ps
module sim_eprom_rd_ctrl;
    localparam int AW = 18;
    localparam int DW = 8;
    localparam int PER = 20;
    localparam int TACC = 120, TCE = 120, TOE = 50, TDF = 40;
    // R8: expected cycle counts worked out by hand for the defaults
    localparam int E_ACC = 6, E_CE = 6, E_OE = 3, E_DF = 2;
    localparam int E_TOTAL = 6;
    localparam int E_LEAD  = E_TOTAL - E_OE;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_ready, rd_valid, mem_ce_n, mem_oe_n;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dq = 8'h00;

    int checks = 0;
    int errors = 0;

    always #(PER/2) clk = ~clk;

    eprom_rd_ctrl u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .rd_data(rd_data), .rd_valid(rd_valid),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_dq(mem_dq)
    );

    function automatic logic [DW-1:0] rom_byte(input logic [AW-1:0] a);
        return a[7:0] ^ {a[15:8]} ^ {a[17:16], 6'b101101};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
        end
    endtask

    // ---------------- memory model with timing ----------------
    realtime t_ce = 0, t_oe = 0, t_adr = 0, t_rel = -1000;
    always @(negedge mem_ce_n) begin
        t_ce = $realtime;
        // R7: bus must have had its release time before the next select
        chk(($realtime - t_rel) >= TDF, "R7 turnaround", int'($realtime - t_rel), TDF);
    end
    always @(negedge mem_oe_n) t_oe = $realtime;
    always @(posedge mem_oe_n) t_rel = $realtime;
    always @(mem_addr) t_adr = $realtime;

    always @(negedge clk) begin
        realtime nxt;
        nxt = $realtime + PER/2;
        if (!mem_ce_n && !mem_oe_n && (nxt - t_ce) >= TCE &&
            (nxt - t_oe) >= TOE && (nxt - t_adr) >= TACC)
            mem_dq = rom_byte(mem_addr);
        else
            mem_dq = ~rom_byte(mem_addr);
    end

    // ---------------- reference model ----------------
    int            ph = 0;   // 0 idle, 1 access, 2 release
    int            t  = 0;
    int            n_taken = 0;
    logic          x_ce = 1, x_oe = 1, x_rv = 0;
    logic [AW-1:0] x_addr = '0;
    logic [DW-1:0] x_data = '0;

    always @(posedge clk) begin
        if (rst) begin
            ph <= 0; t <= 0; x_ce <= 1; x_oe <= 1; x_rv <= 0;
            x_addr <= '0; x_data <= '0;
        end else begin
            x_rv <= 0;
            if (ph == 0) begin
                if (req_valid) begin
                    ph <= 1; t <= 0; x_ce <= 0; x_oe <= (E_LEAD != 0);
                    x_addr <= req_addr; n_taken <= n_taken + 1;
                end
            end else if (ph == 1) begin
                t <= t + 1;
                if (t + 1 == E_LEAD) x_oe <= 0;
                if (t + 1 == E_TOTAL) begin
                    ph <= 2; t <= 0; x_ce <= 1; x_oe <= 1; x_rv <= 1;
                    x_data <= rom_byte(x_addr);
                end
            end else begin
                t <= t + 1;
                if (t + 1 == E_DF) ph <= 0;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk(mem_ce_n === x_ce, "R3 select", mem_ce_n, x_ce);
            chk(mem_oe_n === x_oe, "R4 strobe", mem_oe_n, x_oe);
            chk(req_ready === (ph == 0), "R2/R7 ready", req_ready, ph == 0);
            chk(rd_valid === x_rv, "R5 valid pulse", rd_valid, x_rv);
            if (!x_ce) chk(mem_addr === x_addr, "R3/R9 address", mem_addr, x_addr);
            if (x_rv) begin
                chk(rd_data === x_data, "R5 data", rd_data, x_data);
                chk(mem_ce_n && mem_oe_n, "R6 release with sample", {mem_ce_n, mem_oe_n}, 3);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic read_one(input logic [AW-1:0] a, input bit keep);
        int n0;
        n0 = n_taken;
        req_valid = 1'b1;
        req_addr  = a;
        while (n_taken == n0) @(negedge clk);
        if (!keep) req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (ph != 0) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        chk(mem_ce_n && mem_oe_n && req_ready && !rd_valid, "R1 reset",
            {mem_ce_n, mem_oe_n, req_ready, rd_valid}, 4'b1110);
        rst = 1'b0;
        @(negedge clk);
        chk(mem_ce_n && mem_oe_n && req_ready && !rd_valid, "R1 after reset",
            {mem_ce_n, mem_oe_n, req_ready, rd_valid}, 4'b1110);

        // R8/R4: oe must fall exactly E_LEAD edges after select
        read_one(18'h00000, 1'b0);
        repeat (E_LEAD - 1) @(negedge clk);
        chk(mem_oe_n === 1'b1, "R4 R8 strobe still high", mem_oe_n, 1);
        @(negedge clk);
        chk(mem_oe_n === 1'b0, "R4 R8 strobe low", mem_oe_n, 0);
        wait_idle();
        repeat (3) @(negedge clk);

        read_one(18'h3FFFF, 1'b0); wait_idle(); @(negedge clk);
        read_one(18'h12345, 1'b0); wait_idle(); repeat (2) @(negedge clk);

        // back-to-back with valid held high
        for (int i = 0; i < 6; i++) read_one(AW'(18'h0A5A5 + i * 18'h01111), 1'b1);
        req_valid = 1'b0;
        wait_idle();

        // R9: request changes while busy are ignored
        begin
            int n1;
            read_one(18'h2BEEF, 1'b1);
            n1 = n_taken;
            for (int k = 0; k < E_TOTAL + E_DF - 2; k++) begin
                req_addr = AW'(18'h1C0DE + k * 18'h00377);
                @(negedge clk);
            end
            req_valid = 1'b0;
            wait_idle();
            repeat (4) @(negedge clk);
            chk(n_taken == n1 && mem_ce_n, "R9 no extra access", n_taken, n1);
        end

        for (int i = 0; i < 20; i++) begin
            read_one(AW'(i * 18'h0D1F3 + 7), 1'b0);
            repeat (i % 3) @(negedge clk);
        end
        wait_idle();
        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(PER * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule